// File: doc/BRIEF.md
# Audio serial frame transmitter

This block sends audio samples over a synchronous serial link in master mode. Samples are written through a small register port into a 32-entry transmit queue. The block derives a bit clock from its own clock (the master clock) and builds frames out of queued words. Each frame carries a programmable number of words. Word 0 and the later words each have their own width, and a frame sync of programmable length and polarity marks the start of each frame. The bit order within a 32-bit queue word is also programmable: the index of the first bit sent, and whether the index moves down or up from there. The frame sync can be placed one bit early, as in the usual two-channel I2S format.

A state machine with three states drives the serial side. IDLE holds the outputs quiet. LEAD presents one lead bit after the transmitter is enabled. SHIFT sends frame bits without end. The transitions are:
- IDLE→LEAD on the first driving bit-clock edge that occurs while the transmitter is enabled.
- LEAD→SHIFT on the next driving edge.
- SHIFT→SHIFT on every edge.
- Any state→IDLE as soon as the transmitter is disabled.

The queue level drives a DMA request through a watermark. A word that starts while the queue is empty raises a sticky error flag that can drive an interrupt.

Register map, as word addresses on `reg_addr`:
- 0, control: bit 31 transmit enable, bit 28 bit-clock enable, bit 18 error flag (reads the flag; writing 1 clears it), bit 10 error interrupt enable, bit 0 DMA request enable.
- 1, clock: [7:0] divider, bit 8 bit-clock invert, bit 9 master drive enable.
- 2, frame: [4:0] words per frame minus one, [12:8] sync length minus one, bit 16 MSB-first, bit 17 early sync, bit 18 sync active-low, [28:24] watermark.
- 3, word: [4:0] word-0 width minus one, [12:8] later-word width minus one, [20:16] first-bit index.
- 4, data: a write pushes a word; a read returns the queue level.

Top module: `audio_frame_tx`

## Requirements
- R1: After reset:
  - all registers read 0;
  - `sdata`, `fsync`, `bclk`, `bclk_oe`, `dma_req` and `irq` are 0.
- R2: Bit clock:
  - With bit-clock enable set, the period of `bclk` is 2*(divider+1) clock cycles.
  - Clock-register bit 8 inverts `bclk`.
  - `sdata` changes only on the driving edge, where `bclk` returns to its idle level, so it is stable at the sampling edge.
- R3: A frame holds (frame[4:0]+1) words. Word 0 is (word[4:0]+1) bits wide and every later word is (word[12:8]+1) bits wide. Frames follow each other with no gap bits.
- R4: Bit order:
  - The first bit of a word is queue-word bit word[20:16].
  - With frame bit 16 set, each following bit index is one lower; with it clear, one higher.
  - Indices wrap modulo 32.
- R5: Frame sync:
  - The sync is active for (frame[12:8]+1) bit clocks.
  - It starts with the first data bit of a frame, or one bit clock earlier when frame bit 17 is set.
  - `fsync` is the active level XOR frame bit 18.
- R6: After transmit enable, one lead bit with `sdata`=0 precedes the first frame. The sync is active during the lead bit only in early mode.
- R7: Queue underrun:
  - A word that starts with an empty queue is sent as zeros and sets the error flag (control bit 18).
  - The flag stays set until a control write with bit 18 = 1.
  - `irq` equals the flag AND control bit 10.
- R8: The queue holds 32 words. A push into a full queue is dropped, and the data register reads the level.
- R9: `dma_req` is high when DMA enable and transmit enable are set and the queue level is at or below frame[28:24].
- R10: Writes to the clock, frame and word registers are ignored while transmit enable is set.
- R11: `bclk_oe` and `fsync_oe` follow clock-register bit 9.
- R12: While transmit is disabled, `sdata` is 0 and `fsync` sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bclk | output | 1 | Bit clock |
| bclk_oe | output | 1 | Bit clock drive enable |
| fsync | output | 1 | Frame sync |
| fsync_oe | output | 1 | Frame sync drive enable |
| sdata | output | 1 | Serial data |
| dma_req | output | 1 | Watermark DMA request |
| irq | output | 1 | Underrun interrupt |

## Verification
The bench builds the block with its default 32-word queue and 8-bit divider. With that depth, the dropped 33rd push is reached in a short directed run. The divider register is set to values from 0 to 3, so bit periods stay between 2 and 8 cycles. That keeps two full frames and the following underrun within a few hundred bit clocks for each table vector. The vectors cover both bit orders, a first-bit index that wraps past bit 0, mono and three-word frames, inverted clock and sync polarity, and early and normal sync.

// File: rtl/aft_pkg.sv
package aft_pkg;
    localparam int DW     = 32;
    localparam int FLD_W  = $clog2(DW);
    localparam int DIV_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CLK   = 3'd1;
    localparam logic [ADDR_W-1:0] A_FRAME = 3'd2;
    localparam logic [ADDR_W-1:0] A_WORD  = 3'd3;
    localparam logic [ADDR_W-1:0] A_DATA  = 3'd4;

    localparam int B_TXEN  = 31;
    localparam int B_BCKEN = 28;
    localparam int B_ERR   = 18;
    localparam int B_ERRIE = 10;
    localparam int B_DMAEN = 0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2
    } fr_state_t;

    typedef struct packed {
        logic             tx_en;
        logic             bclk_en;
        logic             err_ie;
        logic             dma_en;
        logic [DIV_W-1:0] div;
        logic             bclk_pol;
        logic             master;
        logic [FLD_W-1:0] frm;
        logic [FLD_W-1:0] syn;
        logic             msb;
        logic             early;
        logic             fs_low;
        logic [FLD_W-1:0] wm;
        logic [FLD_W-1:0] w0;
        logic [FLD_W-1:0] wn;
        logic [FLD_W-1:0] fbt;
    } cfg_t;

    localparam int FROZEN_W = DIV_W + 5 + 6 * FLD_W;
endpackage

// File: rtl/aft_regs.sv
module aft_regs import aft_pkg::*; #(
    parameter int LVL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              err_set,
    input  logic [LVL_W-1:0]  level,
    output cfg_t              cfg,
    output logic              err_flag,
    output logic              clr_err,
    output logic              push,
    output logic [DW-1:0]     rdata
);
    logic wr_ctrl;
    logic wr_cfg_ok;
    logic unused_wbits;

    assign wr_ctrl      = we && (addr == A_CTRL);
    assign wr_cfg_ok    = we && !cfg.tx_en;
    assign clr_err      = wr_ctrl && wdata[B_ERR];
    assign push         = we && (addr == A_DATA);
    assign unused_wbits = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg      <= '0;
            err_flag <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                cfg.tx_en   <= wdata[B_TXEN];
                cfg.bclk_en <= wdata[B_BCKEN];
                cfg.err_ie  <= wdata[B_ERRIE];
                cfg.dma_en  <= wdata[B_DMAEN];
            end
            if (wr_cfg_ok && addr == A_CLK) begin
                cfg.div      <= wdata[DIV_W-1:0];
                cfg.bclk_pol <= wdata[DIV_W];
                cfg.master   <= wdata[DIV_W+1];
            end
            if (wr_cfg_ok && addr == A_FRAME) begin
                cfg.frm    <= wdata[0 +: FLD_W];
                cfg.syn    <= wdata[8 +: FLD_W];
                cfg.msb    <= wdata[16];
                cfg.early  <= wdata[17];
                cfg.fs_low <= wdata[18];
                cfg.wm     <= wdata[24 +: FLD_W];
            end
            if (wr_cfg_ok && addr == A_WORD) begin
                cfg.w0  <= wdata[0 +: FLD_W];
                cfg.wn  <= wdata[8 +: FLD_W];
                cfg.fbt <= wdata[16 +: FLD_W];
            end
            if (err_set) begin
                err_flag <= 1'b1;
            end else if (clr_err) begin
                err_flag <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[B_TXEN]  = cfg.tx_en;
                rdata[B_BCKEN] = cfg.bclk_en;
                rdata[B_ERR]   = err_flag;
                rdata[B_ERRIE] = cfg.err_ie;
                rdata[B_DMAEN] = cfg.dma_en;
            end
            A_CLK: begin
                rdata[DIV_W-1:0] = cfg.div;
                rdata[DIV_W]     = cfg.bclk_pol;
                rdata[DIV_W+1]   = cfg.master;
            end
            A_FRAME: begin
                rdata[0 +: FLD_W]  = cfg.frm;
                rdata[8 +: FLD_W]  = cfg.syn;
                rdata[16]          = cfg.msb;
                rdata[17]          = cfg.early;
                rdata[18]          = cfg.fs_low;
                rdata[24 +: FLD_W] = cfg.wm;
            end
            A_WORD: begin
                rdata[0 +: FLD_W]  = cfg.w0;
                rdata[8 +: FLD_W]  = cfg.wn;
                rdata[16 +: FLD_W] = cfg.fbt;
            end
            A_DATA:  rdata[LVL_W-1:0] = level;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/aft_fifo.sv
module aft_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [LW-1:0]    level
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/aft_bclk_gen.sv
module aft_bclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             phase,
    output logic             drive_tick
);
    logic [DIV_W-1:0] cnt;
    logic             half_done;

    assign half_done  = (cnt == div);
    assign drive_tick = en && half_done && phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (!en) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (half_done) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/aft_framer.sv
module aft_framer import aft_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [FLD_W-1:0] frm,
    input  logic [FLD_W-1:0] syn,
    input  logic [FLD_W-1:0] w0,
    input  logic [FLD_W-1:0] wn,
    input  logic [FLD_W-1:0] fbt,
    input  logic             msb,
    input  logic             early,
    input  logic [DW-1:0]    head,
    input  logic             empty,
    output logic             pop,
    output logic             underrun,
    output logic             sdata_q,
    output logic             fs_q,
    output fr_state_t        state
);
    fr_state_t        state_nx;
    logic [FLD_W-1:0] bit_cnt, word_idx, fs_left;
    logic [DW-1:0]    word_q, cur_word;
    logic [FLD_W-1:0] wlen, pos;
    logic             step, word_start, last_bit, last_word, fs_start, bit_out;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tick && run) state_nx = ST_LEAD;
            ST_LEAD:  if (tick)        state_nx = ST_SHIFT;
            ST_SHIFT:                  state_nx = ST_SHIFT;
            default:                   state_nx = ST_IDLE;
        endcase
        if (!run) begin
            state_nx = ST_IDLE;
        end
    end

    // per-bit decisions
    always_comb begin
        step       = tick && run && (state != ST_IDLE);
        wlen       = (word_idx == '0) ? w0 : wn;
        word_start = (bit_cnt == '0);
        last_bit   = (bit_cnt == wlen);
        last_word  = (word_idx == frm);
        pop        = step && word_start && !empty;
        underrun   = step && word_start && empty;
        cur_word   = word_start ? (empty ? '0 : head) : word_q;
        pos        = msb ? (fbt - bit_cnt) : (fbt + bit_cnt);
        bit_out    = cur_word[pos];
        fs_start   = early ? (last_bit && last_word)
                           : (word_start && word_idx == '0);
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdata_q  <= 1'b0;
            fs_q     <= 1'b0;
            fs_left  <= '0;
            bit_cnt  <= '0;
            word_idx <= '0;
            word_q   <= '0;
        end else if (!run) begin
            sdata_q  <= 1'b0;
            fs_q     <= 1'b0;
            fs_left  <= '0;
            bit_cnt  <= '0;
            word_idx <= '0;
        end else if (tick && state == ST_IDLE) begin
            sdata_q  <= 1'b0;
            fs_q     <= early;
            fs_left  <= early ? syn : '0;
            bit_cnt  <= '0;
            word_idx <= '0;
        end else if (step) begin
            sdata_q <= bit_out;
            if (word_start) begin
                word_q <= cur_word;
            end
            if (last_bit) begin
                bit_cnt  <= '0;
                word_idx <= last_word ? '0 : word_idx + 1'b1;
            end else begin
                bit_cnt  <= bit_cnt + 1'b1;
            end
            if (fs_start) begin
                fs_q    <= 1'b1;
                fs_left <= syn;
            end else if (fs_left != '0) begin
                fs_q    <= 1'b1;
                fs_left <= fs_left - 1'b1;
            end else begin
                fs_q    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx import aft_pkg::*; #(
    parameter int FIFO_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              bclk,
    output logic              bclk_oe,
    output logic              fsync,
    output logic              fsync_oe,
    output logic              sdata,
    output logic              dma_req,
    output logic              irq
);
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

    cfg_t             cfg;
    logic             err_flag, clr_err, push, pop, underrun;
    logic             empty, full, phase, tick, sdata_q, fs_q;
    logic [DW-1:0]    head;
    logic [LVL_W-1:0] level;
    fr_state_t        state;
    logic             unused_misc;

    assign unused_misc = ^{full, state};

    aft_regs #(.LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .err_set(underrun), .level(level),
        .cfg(cfg), .err_flag(err_flag), .clr_err(clr_err),
        .push(push), .rdata(reg_rdata)
    );

    aft_fifo #(.WIDTH(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(reg_wdata),
        .pop(pop), .head(head), .empty(empty), .full(full), .level(level)
    );

    aft_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk(clk), .rst_n(rst_n), .en(cfg.bclk_en), .div(cfg.div),
        .phase(phase), .drive_tick(tick)
    );

    aft_framer u_framer (
        .clk(clk), .rst_n(rst_n), .run(cfg.tx_en), .tick(tick),
        .frm(cfg.frm), .syn(cfg.syn), .w0(cfg.w0), .wn(cfg.wn),
        .fbt(cfg.fbt), .msb(cfg.msb), .early(cfg.early),
        .head(head), .empty(empty), .pop(pop), .underrun(underrun),
        .sdata_q(sdata_q), .fs_q(fs_q), .state(state)
    );

    assign bclk     = phase ^ cfg.bclk_pol;
    assign fsync    = fs_q ^ cfg.fs_low;
    assign sdata    = sdata_q;
    assign bclk_oe  = cfg.master;
    assign fsync_oe = cfg.master;
    assign dma_req  = cfg.dma_en && cfg.tx_en && (level <= LVL_W'(cfg.wm));
    assign irq      = err_flag && cfg.err_ie;
endmodule

// File: rtl/aft_checker.sv
module aft_checker import aft_pkg::*; #(
    parameter int LVL_W = 6,
    parameter int DEPTH = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tx_en,
    input logic                dma_en,
    input logic                bclk_pol,
    input logic                fs_low,
    input logic                bclk,
    input logic                sdata,
    input logic                fsync,
    input logic                dma_req,
    input logic                err_flag,
    input logic                clr_err,
    input logic [LVL_W-1:0]    level,
    input logic [FROZEN_W-1:0] frozen
);
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_en) |-> $stable(frozen))
        else $error("R10 configuration changed while enabled");

    a_r2_drive_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && !$stable(sdata)) |-> (!$stable(bclk) && bclk == bclk_pol))
        else $error("R2 data moved off the driving edge");

    a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH))
        else $error("R8 queue level above depth");

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_flag) && !$past(clr_err)) |-> err_flag)
        else $error("R7 error flag cleared without a write");

    a_r9_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (tx_en && dma_en))
        else $error("R9 request without enables");

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !$past(tx_en)) |-> (sdata == 1'b0 && fsync == fs_low))
        else $error("R12 outputs active while disabled");
endmodule

bind audio_frame_tx aft_checker #(.LVL_W(LVL_W), .DEPTH(FIFO_DEPTH)) u_aft_checker (
    .clk(clk), .rst_n(rst_n), .tx_en(cfg.tx_en), .dma_en(cfg.dma_en),
    .bclk_pol(cfg.bclk_pol), .fs_low(cfg.fs_low), .bclk(bclk),
    .sdata(sdata), .fsync(fsync), .dma_req(dma_req), .err_flag(err_flag),
    .clr_err(clr_err), .level(level),
    .frozen({cfg.div, cfg.bclk_pol, cfg.master, cfg.frm, cfg.syn, cfg.msb,
             cfg.early, cfg.fs_low, cfg.wm, cfg.w0, cfg.wn, cfg.fbt})
);

// File: tb/audio_frame_tx_bench.sv
module audio_frame_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        bclk, bclk_oe, fsync, fsync_oe, sdata, dma_req, irq;

    always #10 clk = ~clk;

    audio_frame_tx u_audio_frame_tx (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bclk(bclk),
        .bclk_oe(bclk_oe), .fsync(fsync), .fsync_oe(fsync_oe),
        .sdata(sdata), .dma_req(dma_req), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // capture of each sampling edge
    int   cyc = 0;
    always @(posedge clk) cyc++;
    bit   cap_on = 1'b0;
    logic samp_lvl = 1'b1;
    logic cur_fslow = 1'b0;
    logic prev_bclk = 1'b0;
    int   ncap = 0;
    logic cap_sd [512];
    logic cap_fs [512];
    int   cap_t  [512];

    always @(negedge clk) begin
        if (cap_on && prev_bclk != bclk && bclk == samp_lvl && ncap < 512) begin
            cap_sd[ncap] = sdata;
            cap_fs[ncap] = fsync ^ cur_fslow;
            cap_t[ncap]  = cyc;
            ncap++;
        end
        prev_bclk = bclk;
    end

    typedef struct packed {
        logic [7:0]  div;
        logic [4:0]  frm;
        logic [4:0]  syn;
        logic [4:0]  w0;
        logic [4:0]  wn;
        logic [4:0]  fbt;
        logic        msb;
        logic        early;
        logic        bpol;
        logic        fslow;
        logic [31:0] seed;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{8'd0, 5'd1, 5'd23, 5'd23, 5'd23, 5'd31, 1'b1, 1'b1, 1'b0, 1'b0, 32'hA5C3_0F71},
        '{8'd1, 5'd1, 5'd0,  5'd15, 5'd15, 5'd15, 1'b1, 1'b0, 1'b1, 1'b1, 32'h1234_5678},
        '{8'd2, 5'd2, 5'd3,  5'd7,  5'd11, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF},
        '{8'd0, 5'd0, 5'd4,  5'd31, 5'd31, 5'd31, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0F0F_3C3C},
        '{8'd3, 5'd1, 5'd1,  5'd4,  5'd9,  5'd2,  1'b1, 1'b1, 1'b0, 1'b1, 32'h8421_7BDE}
    };

    function automatic logic [31:0] word_val(logic [31:0] s, int j);
        return s + 32'(j) * 32'h9E37_79B9;
    endfunction

    function automatic int frame_bits(vec_t v);
        return (int'(v.w0) + 1) + int'(v.frm) * (int'(v.wn) + 1);
    endfunction

    function automatic logic exp_sd(vec_t v, int k);
        int fw, f, r, word, b, pos;
        logic [31:0] w;
        fw = int'(v.frm) + 1;
        f  = k / frame_bits(v);
        r  = k % frame_bits(v);
        if (r <= int'(v.w0)) begin
            word = f * fw; b = r;
        end else begin
            r    = r - (int'(v.w0) + 1);
            word = f * fw + 1 + r / (int'(v.wn) + 1);
            b    = r % (int'(v.wn) + 1);
        end
        pos = v.msb ? ((int'(v.fbt) - b) & 31) : ((int'(v.fbt) + b) & 31);
        w = word_val(v.seed, word);
        return w[pos];
    endfunction

    function automatic logic exp_fs(vec_t v, int k);
        for (int f = 0; f < 3; f++) begin
            int p;
            p = f * frame_bits(v) - (v.early ? 1 : 0);
            if (k >= p && k <= p + int'(v.syn)) return 1'b1;
        end
        return 1'b0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R6 watchdog expired: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sdata == 1'b0 && fsync == 1'b0, "R1", "sdata/fsync", {sdata, fsync}, 0);
        chk(bclk == 1'b0 && bclk_oe == 1'b0, "R1", "bclk/oe", {bclk, bclk_oe}, 0);
        chk(dma_req == 1'b0 && irq == 1'b0, "R1", "dma/irq", {dma_req, irq}, 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk(d == 0, "R1", "register reset value", d, 0);
        end

        // table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int   fb, need, bad_sd, bad_fs, first;
            v  = VECS[i];
            fb = frame_bits(v);
            wr(3'd0, 32'h0);
            wr(3'd0, 32'h1 << 18);
            wr(3'd1, {22'd0, 1'b1, v.bpol, v.div});
            wr(3'd2, {3'd0, 5'd0, 5'd0, v.fslow, v.early, v.msb, 3'd0, v.syn, 3'd0, v.frm});
            wr(3'd3, {11'd0, v.fbt, 3'd0, v.wn, 3'd0, v.w0});
            @(negedge clk);
            chk(bclk == v.bpol, "R2", "bclk idle level", bclk, v.bpol);
            chk(fsync == v.fslow, "R12", "fsync idle level", fsync, v.fslow);
            for (int j = 0; j < 2 * (int'(v.frm) + 1); j++) wr(3'd4, word_val(v.seed, j));
            samp_lvl  = ~v.bpol;
            cur_fslow = v.fslow;
            ncap = 0; cap_on = 1'b1;
            wr(3'd0, (32'h1 << 31) | (32'h1 << 28) | (32'h1 << 10));
            need = 2 * fb + 3;
            while (ncap < need) @(negedge clk);
            cap_on = 1'b0;

            chk(cap_t[3] - cap_t[2] == 2 * (int'(v.div) + 1), "R2", "bit period",
                cap_t[3] - cap_t[2], 2 * (int'(v.div) + 1));
            chk(cap_sd[1] == 1'b0 && cap_fs[1] == v.early, "R6", "lead bit data/sync",
                {cap_sd[1], cap_fs[1]}, {1'b0, v.early});
            bad_sd = 0; bad_fs = 0; first = -1;
            for (int k = 0; k < 2 * fb; k++) begin
                if (cap_sd[k + 2] != exp_sd(v, k)) begin
                    bad_sd++;
                    if (first < 0) first = k;
                end
                if (cap_fs[k + 2] != exp_fs(v, k)) bad_fs++;
            end
            chk(bad_sd == 0, "R3", "frame bit mismatches (R4 order)", bad_sd, 0);
            if (bad_sd != 0) $display("  first mismatch at bit %0d of vector %0d", first, i);
            chk(bad_fs == 0, "R5", "frame sync mismatches", bad_fs, 0);
            chk(cap_sd[2 * fb + 2] == 1'b0, "R7", "underrun data", cap_sd[2 * fb + 2], 0);
            rd(3'd0, d);
            chk(d[18] == 1'b1 && irq == 1'b1, "R7", "error flag/irq", {d[18], irq}, 3);
        end

        // R7: flag sticky, W1C
        wr(3'd0, 32'h1 << 10);
        rd(3'd0, d);
        chk(d[18] == 1'b1 && irq == 1'b1, "R7", "flag kept on write 0", {d[18], irq}, 3);
        wr(3'd0, 32'h0);
        chk(irq == 1'b0, "R7", "irq masked", irq, 0);
        wr(3'd0, (32'h1 << 10) | (32'h1 << 18));
        rd(3'd0, d);
        chk(d[18] == 1'b0 && irq == 1'b0, "R7", "flag cleared", {d[18], irq}, 0);
        chk(sdata == 1'b0, "R12", "sdata while disabled", sdata, 0);

        // R10: frozen while enabled
        wr(3'd1, 32'h0000_0205);
        wr(3'd0, 32'h1 << 31);
        wr(3'd1, 32'h0000_00FF);
        rd(3'd1, d);
        chk(d == 32'h0000_0205, "R10", "clock register while enabled", d, 32'h205);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0000_0011);
        rd(3'd1, d);
        chk(d == 32'h0000_0011, "R10", "clock register while disabled", d, 32'h11);
        chk(bclk_oe == 1'b0 && fsync_oe == 1'b0, "R11", "drive enables off", {bclk_oe, fsync_oe}, 0);
        wr(3'd1, 32'h0000_0200);
        chk(bclk_oe == 1'b1 && fsync_oe == 1'b1, "R11", "drive enables on", {bclk_oe, fsync_oe}, 3);

        // R9 watermark, R8 depth
        wr(3'd2, 32'h2 << 24);
        wr(3'd0, (32'h1 << 31) | 32'h1);
        chk(dma_req == 1'b1, "R9", "request at level 0", dma_req, 1);
        wr(3'd4, 32'h1); wr(3'd4, 32'h2);
        chk(dma_req == 1'b1, "R9", "request at level 2", dma_req, 1);
        wr(3'd4, 32'h3);
        chk(dma_req == 1'b0, "R9", "no request at level 3", dma_req, 0);
        wr(3'd0, 32'h1 << 31);
        wr(3'd2, 32'h1F << 24);
        rd(3'd2, d);
        chk(d[28:24] == 5'd2, "R10", "watermark frozen", d[28:24], 2);
        for (int j = 0; j < 30; j++) wr(3'd4, 32'(j));
        rd(3'd4, d);
        chk(d == 32, "R8", "level when full plus one", d, 32);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule